// File: doc/BRIEF.md
# Fused Branch/ALU Execution Unit

A single-issue execution slice that accepts one operation per cycle and runs plain integer arithmetic, conditional branches, direct and indirect jumps, and two kinds of paired operation that an earlier stage has merged into one slot. The first paired form adds an immediate to one register, writes the sum back, and jumps indirectly through a second register. The second paired form loads an immediate into a destination and, in the same slot, compares that immediate against a register to decide a branch.

To serve both halves of a paired operation at once, the unit has three separate datapaths: an arithmetic adder, a target adder, and a magnitude comparator. Each operation produces a register write request, the resolved next PC, a taken flag and a mispredict flag. The mispredict flag is computed against the direction and target that the front end supplied. All results are registered one cycle after the operation is presented.

Control code layout (8 bits): bits [3:0] select the operation, bits [6:4] select the comparison, and bit 7 requests a link write.

Top module: `fused_bru`

## Requirements
- R1: Results appear exactly one cycle after `valid_i` is high, together with `valid_o`. While `valid_o` is low, `wr_en_o`, `taken_o` and `mispred_o` are low.
- R2: The operation codes 0 to 5 select arithmetic: 0 rs1+rs2, 1 rs1-rs2, 2 rs1+imm, 3 AND, 4 OR, 5 XOR. Each writes its result with `wr_en_o`=1, `taken_o`=0, `mispred_o`=0 and `target_o`=PC+4. Codes 12 to 15 behave the same way except that they write nothing.
- R3: Operation code 9 is the fused add/indirect jump. It writes rs2+imm and, in the same result, is taken to rs1 with bit 0 cleared.
- R4: Operation codes 10 and 11 are the fused immediate branch. Code 10 compares imm (left) against rs1 (right), and code 11 compares rs1 (left) against imm (right). The taken target is PC+boff. Both codes write imm to the destination.
- R5: Operation code 6 is a conditional branch that compares rs1 (left) against rs2 (right). Comparison codes: 0 eq, 1 ne, 4 signed lt, 5 signed ge, 6 unsigned lt, 7 unsigned ge. Codes 2 and 3 are never taken. The target is PC+boff when taken and PC+4 otherwise.
- R6: Operation code 7 is a direct jump to PC+boff. Operation code 8 is an indirect jump to rs1+imm with bit 0 cleared. Both are always taken.
- R7: Operation codes 6, 7 and 8 write PC+4 when control bit 7 is set, and write nothing when it is clear.
- R8: For operation codes 6 to 11, `mispred_o` is set when the predicted direction differs from the actual one, or when both are taken and the predicted target differs from the resolved target. A correct prediction raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present |
| ctrl_i | input | 8 | Control code: op [3:0], compare [6:4], link [7] |
| rs1_i | input | W | First register operand |
| rs2_i | input | W | Second register operand |
| imm_i | input | W | Data immediate |
| boff_i | input | W | PC-relative branch/jump offset |
| pc_i | input | W | PC of the operation |
| pred_taken_i | input | 1 | Predicted direction |
| pred_tgt_i | input | W | Predicted target |
| valid_o | output | 1 | Result valid |
| wr_en_o | output | 1 | Register write request |
| wr_data_o | output | W | Register write data |
| taken_o | output | 1 | Control transfer taken |
| target_o | output | W | Resolved next PC |
| mispred_o | output | 1 | Prediction was wrong |

## Verification
The register result and the control-flow decision can land in the same result: the fused add/indirect jump yields a sum and a redirect at once, and the fused immediate branch yields an immediate write and a compare outcome at once. The bench exercises these cases by choosing operands that make the sum, the compare outcome and the jump target all different from one another. Examples are an odd jump register, and an immediate that is less than the register on one side of the compare but not the other. Every field of each result is then checked against an expected value that the bench computes on its own. Each paired case is run once with a correct prediction and once with a wrong one.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_ADDI = 4'd2,
    OP_AND  = 4'd3,  OP_OR   = 4'd4,  OP_XOR  = 4'd5,
    OP_BR   = 4'd6,  OP_JAL  = 4'd7,  OP_JALR = 4'd8,
    OP_FAJR = 4'd9,  OP_FBRL = 4'd10, OP_FBRR = 4'd11,
    OP_R12  = 4'd12, OP_R13  = 4'd13, OP_R14  = 4'd14, OP_R15 = 4'd15
  } op_e;

  localparam logic [2:0] CMP_EQ  = 3'd0;
  localparam logic [2:0] CMP_NE  = 3'd1;
  localparam logic [2:0] CMP_LT  = 3'd4;
  localparam logic [2:0] CMP_GE  = 3'd5;
  localparam logic [2:0] CMP_LTU = 3'd6;
  localparam logic [2:0] CMP_GEU = 3'd7;
endpackage

// File: rtl/fbu_alu.sv
module fbu_alu
  import fbu_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op_i,
  input  logic [W-1:0] rs1_i,
  input  logic [W-1:0] rs2_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] res_o
);
  logic         sub;
  logic [W-1:0] opa, opb, sum;

  // the fused form adds imm to rs2; rs1 is held for the jump target
  assign opa = (op_i == OP_FAJR) ? rs2_i : rs1_i;
  assign opb = (op_i == OP_ADD || op_i == OP_SUB) ? rs2_i : imm_i;
  assign sub = (op_i == OP_SUB);
  assign sum = opa + (sub ? ~opb : opb) + {{(W-1){1'b0}}, sub};

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = rs1_i & rs2_i;
      OP_OR:   res_o = rs1_i | rs2_i;
      OP_XOR:  res_o = rs1_i ^ rs2_i;
      default: res_o = sum;
    endcase
  end
endmodule

// File: rtl/fbu_cmp.sv
module fbu_cmp
  import fbu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   cond_i,
  output logic         take_o
);
  logic eq, lts, ltu;

  assign eq  = (a_i == b_i);
  assign lts = ($signed(a_i) < $signed(b_i));
  assign ltu = (a_i < b_i);

  always_comb begin
    case (cond_i)
      CMP_EQ:  take_o = eq;
      CMP_NE:  take_o = !eq;
      CMP_LT:  take_o = lts;
      CMP_GE:  take_o = !lts;
      CMP_LTU: take_o = ltu;
      CMP_GEU: take_o = !ltu;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fused_bru.sv
module fused_bru
  import fbu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [7:0]   ctrl_i,
  input  logic [W-1:0] rs1_i,
  input  logic [W-1:0] rs2_i,
  input  logic [W-1:0] imm_i,
  input  logic [W-1:0] boff_i,
  input  logic [W-1:0] pc_i,
  input  logic         pred_taken_i,
  input  logic [W-1:0] pred_tgt_i,
  output logic         valid_o,
  output logic         wr_en_o,
  output logic [W-1:0] wr_data_o,
  output logic         taken_o,
  output logic [W-1:0] target_o,
  output logic         mispred_o
);
  localparam logic [W-1:0] INSN_BYTES = W'(4);
  localparam logic [W-1:0] ALIGN_MASK = ~W'(1);

  op_e          op;
  logic [2:0]   cond;
  logic         link;
  logic [W-1:0] alu_res, cmp_a, cmp_b, t_base, t_off, t_sum, tgt, pc4, nxt;
  logic         cmp_take, is_cbr, is_jmp, is_arith, taken, wen, misp;
  logic [W-1:0] wdata;

  assign op   = op_e'(ctrl_i[3:0]);
  assign cond = ctrl_i[6:4];
  assign link = ctrl_i[7];

  fbu_alu #(.W(W)) u_alu (
    .op_i(op), .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i), .res_o(alu_res)
  );

  // comparator is separate from the arithmetic adder so both run together
  always_comb begin
    cmp_a = rs1_i;
    cmp_b = rs2_i;
    if (op == OP_FBRL) begin cmp_a = imm_i; cmp_b = rs1_i; end
    if (op == OP_FBRR) begin cmp_a = rs1_i; cmp_b = imm_i; end
  end

  fbu_cmp #(.W(W)) u_cmp (.a_i(cmp_a), .b_i(cmp_b), .cond_i(cond), .take_o(cmp_take));

  assign is_cbr   = (op == OP_BR) || (op == OP_FBRL) || (op == OP_FBRR);
  assign is_jmp   = (op == OP_JAL) || (op == OP_JALR) || (op == OP_FAJR);
  assign is_arith = (op <= OP_XOR);

  // third adder: branch / jump target
  assign t_base = (op == OP_JALR) ? rs1_i : pc_i;
  assign t_off  = (op == OP_JALR) ? imm_i : boff_i;
  assign t_sum  = t_base + t_off;
  always_comb begin
    tgt = t_sum;
    if (op == OP_FAJR) tgt = rs1_i & ALIGN_MASK;
    if (op == OP_JALR) tgt = t_sum & ALIGN_MASK;
  end

  assign pc4   = pc_i + INSN_BYTES;
  assign taken = is_jmp || (is_cbr && cmp_take);
  assign nxt   = taken ? tgt : pc4;
  assign misp  = (is_cbr || is_jmp) &&
                 ((pred_taken_i != taken) || (taken && (pred_tgt_i != tgt)));

  always_comb begin
    wen   = 1'b0;
    wdata = alu_res;
    if (is_arith || op == OP_FAJR) begin
      wen = 1'b1;
    end else if (op == OP_FBRL || op == OP_FBRR) begin
      wen   = 1'b1;
      wdata = imm_i;
    end else if (op == OP_BR || op == OP_JAL || op == OP_JALR) begin
      wen   = link;
      wdata = pc4;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      taken_o   <= 1'b0;
      target_o  <= '0;
      mispred_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      wr_en_o   <= valid_i && wen;
      wr_data_o <= wdata;
      taken_o   <= valid_i && taken;
      target_o  <= nxt;
      mispred_o <= valid_i && misp;
    end
  end

  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!wr_en_o && !taken_o && !mispred_o));

  assert_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_fused_jr_dual_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i[3:0] == 4'd9) |=>
      (wr_en_o && taken_o && wr_data_o == $past(rs2_i + imm_i) && !target_o[0]));

  assert_fused_imm_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (ctrl_i[3:0] == 4'd10 || ctrl_i[3:0] == 4'd11)) |=>
      (wr_en_o && wr_data_o == $past(imm_i)));

  assert_arith_no_flow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i[3:0] <= 4'd5) |=> (!taken_o && !mispred_o && wr_en_o));

  assert_hit_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o == $past(pred_taken_i) &&
     (!taken_o || target_o == $past(pred_tgt_i))) |-> !mispred_o);
endmodule

// File: tb/fused_bru_bench.sv
module fused_bru_bench;
  localparam int  W   = 32;
  localparam time CLK = 10ns;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         valid_i = 1'b0, pred_taken_i = 1'b0;
  logic [7:0]   ctrl_i = '0;
  logic [W-1:0] rs1_i = '0, rs2_i = '0, imm_i = '0, boff_i = '0, pc_i = '0, pred_tgt_i = '0;
  logic         valid_o, wr_en_o, taken_o, mispred_o;
  logic [W-1:0] wr_data_o, target_o;

  typedef struct {
    logic         we;
    logic [W-1:0] wd;
    logic         tk;
    logic [W-1:0] tg;
    logic         mp;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  always #(CLK/2) clk = ~clk;

  fused_bru #(.W(W)) u_fused_bru (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ctrl_i(ctrl_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i), .boff_i(boff_i), .pc_i(pc_i),
    .pred_taken_i(pred_taken_i), .pred_tgt_i(pred_tgt_i),
    .valid_o(valid_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .taken_o(taken_o), .target_o(target_o), .mispred_o(mispred_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic cmp_model(input logic [2:0] c, input logic [W-1:0] a,
                                     input logic [W-1:0] b);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [2:0] cnd, input logic lnk,
                       input logic [W-1:0] r1, input logic [W-1:0] r2,
                       input logic [W-1:0] im, input logic [W-1:0] bo,
                       input logic [W-1:0] pc, input logic pt, input logic [W-1:0] ptg,
                       input string tag);
    exp_t e;
    logic [W-1:0] tgt;
    logic ctl;
    e.tag = tag; e.we = 0; e.wd = 'x; e.tk = 0; ctl = 0; tgt = pc + bo;
    case (op)
      4'd0: begin e.we = 1; e.wd = r1 + r2; end
      4'd1: begin e.we = 1; e.wd = r1 - r2; end
      4'd2: begin e.we = 1; e.wd = r1 + im; end
      4'd3: begin e.we = 1; e.wd = r1 & r2; end
      4'd4: begin e.we = 1; e.wd = r1 | r2; end
      4'd5: begin e.we = 1; e.wd = r1 ^ r2; end
      4'd6: begin ctl = 1; e.tk = cmp_model(cnd, r1, r2); e.we = lnk; e.wd = pc + 4; end
      4'd7: begin ctl = 1; e.tk = 1; e.we = lnk; e.wd = pc + 4; end
      4'd8: begin ctl = 1; e.tk = 1; e.we = lnk; e.wd = pc + 4; tgt = (r1 + im) & ~W'(1); end
      4'd9: begin ctl = 1; e.tk = 1; e.we = 1; e.wd = r2 + im; tgt = r1 & ~W'(1); end
      4'd10: begin ctl = 1; e.tk = cmp_model(cnd, im, r1); e.we = 1; e.wd = im; end
      4'd11: begin ctl = 1; e.tk = cmp_model(cnd, r1, im); e.we = 1; e.wd = im; end
      default: ;
    endcase
    e.tg = e.tk ? tgt : pc + 4;
    e.mp = ctl && ((pt != e.tk) || (e.tk && ptg != tgt));
    @(negedge clk);
    valid_i = 1; ctrl_i = {lnk, cnd, op};
    rs1_i = r1; rs2_i = r2; imm_i = im; boff_i = bo; pc_i = pc;
    pred_taken_i = pt; pred_tgt_i = ptg;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 0; ctrl_i = 8'h09; rs1_i = 32'hFFFF_FFFF; pred_taken_i = 1;
    end
  endtask

  // monitor: sample away from the active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (valid_o) begin
          if (q.size() == 0) chk(0, "R1", "unexpected valid_o", 1, 0);
          else begin
            exp_t e;
            e = q.pop_front();
            chk(wr_en_o == e.we, e.tag, "wr_en", W'(wr_en_o), W'(e.we));
            if (e.we) chk(wr_data_o == e.wd, e.tag, "wr_data", wr_data_o, e.wd);
            chk(taken_o == e.tk, e.tag, "taken", W'(taken_o), W'(e.tk));
            chk(target_o == e.tg, e.tag, "target", target_o, e.tg);
            chk(mispred_o == e.mp, e.tag, "mispred", W'(mispred_o), W'(e.mp));
          end
        end else begin
          chk(!wr_en_o && !taken_o && !mispred_o, "R1", "idle quiet",
              W'({wr_en_o, taken_o, mispred_o}), 0);
          chk(q.size() == 0, "R1", "missing result", W'(q.size()), 0);
        end
      end
    end
  end

  initial begin
    #(CLK * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK * 2);
    chk(!valid_o && !wr_en_o && !taken_o && !mispred_o, "R1", "reset state",
        W'({valid_o, wr_en_o, taken_o, mispred_o}), 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    // R2 arithmetic
    drive(0, 0, 0, 32'd7, 32'd9, 0, 0, 32'h100, 0, 0, "R2 add");
    drive(1, 0, 0, 32'd3, 32'd9, 0, 0, 32'h104, 0, 0, "R2 sub");
    drive(2, 0, 0, 32'd40, 0, 32'hFFFF_FFF8, 0, 32'h108, 0, 0, "R2 addi");
    drive(3, 0, 0, 32'hF0F0, 32'h0FF0, 0, 0, 32'h10C, 0, 0, "R2 and");
    drive(4, 0, 0, 32'hF0F0, 32'h0FF0, 0, 0, 32'h110, 0, 0, "R2 or");
    drive(5, 0, 0, 32'hF0F0, 32'h0FF0, 0, 0, 32'h114, 0, 0, "R2 xor");
    drive(13, 0, 0, 32'd1, 32'd2, 0, 0, 32'h118, 0, 0, "R2 unused code");
    idle(1);
    // R5 conditional compares, signed vs unsigned
    drive(6, 0, 0, 32'd5, 32'd5, 0, 32'h40, 32'h200, 1, 32'h240, "R5 eq taken hit");
    drive(6, 1, 0, 32'd5, 32'd5, 0, 32'h40, 32'h200, 0, 0, "R5 ne not-taken hit");
    drive(6, 4, 0, 32'hFFFF_FFFF, 32'd1, 0, 32'h20, 32'h300, 0, 0, "R5 lt signed taken");
    drive(6, 5, 0, 32'hFFFF_FFFF, 32'd1, 0, 32'h20, 32'h300, 0, 0, "R5 ge signed");
    drive(6, 6, 0, 32'hFFFF_FFFF, 32'd1, 0, 32'h20, 32'h300, 0, 0, "R5 ltu");
    drive(6, 7, 0, 32'hFFFF_FFFF, 32'd1, 0, 32'hFFFF_FFE0, 32'h300, 1, 32'h2E0, "R5 geu back");
    drive(6, 2, 0, 32'd1, 32'd1, 0, 32'h20, 32'h300, 0, 0, "R5 undefined cmp");
    // R8 mispredicts
    drive(6, 0, 0, 32'd1, 32'd2, 0, 32'h40, 32'h400, 1, 32'h440, "R8 dir wrong");
    drive(6, 0, 0, 32'd2, 32'd2, 0, 32'h40, 32'h400, 1, 32'h444, "R8 target wrong");
    drive(6, 0, 0, 32'd2, 32'd2, 0, 32'h40, 32'h400, 0, 0, "R8 predicted not taken");
    // R6 / R7 jumps and link
    drive(7, 0, 1, 0, 0, 0, 32'h80, 32'h500, 1, 32'h580, "R6 R7 jal link");
    drive(8, 0, 0, 32'h1001, 0, 32'h4, 0, 32'h504, 1, 32'h1004, "R6 jalr odd no link");
    drive(8, 0, 1, 32'h2000, 0, 32'h11, 0, 32'h508, 0, 0, "R6 R7 jalr link miss");
    drive(6, 0, 1, 32'd3, 32'd3, 0, 32'h10, 32'h50C, 1, 32'h51C, "R7 branch link");
    idle(1);
    // R3 fused add + indirect jump, both results in one slot
    drive(9, 0, 0, 32'h8001, 32'h7000, 32'd40, 0, 32'h600, 1, 32'h8000, "R3 fused ret hit");
    drive(9, 0, 0, 32'h8003, 32'h7000, 32'hFFFF_FFF0, 0, 32'h604, 1, 32'h8003, "R3 fused ret miss");
    drive(9, 0, 0, 32'h9000, 32'd0, 32'd0, 0, 32'h608, 0, 0, "R3 fused li ret");
    // R4 fused immediate branch, either side
    drive(10, 4, 0, 32'd3, 0, 32'd5, 32'h30, 32'h700, 0, 0, "R4 imm left lt");
    drive(11, 4, 0, 32'd3, 0, 32'd5, 32'h30, 32'h704, 1, 32'h734, "R4 imm right lt");
    drive(10, 0, 0, 32'd5, 0, 32'd5, 32'h30, 32'h708, 0, 0, "R4 imm eq mispred");
    drive(11, 6, 0, 32'hFFFF_FFFB, 0, 32'd5, 32'h30, 32'h70C, 1, 32'h73C, "R4 imm ltu");
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule